// File: doc/BRIEF.md
# Cartridge Register Decoder with Two-Clock Serial EEPROM Control

This block sits between the console CPU bus and a cartridge that carries a switchable program ROM, two serial EEPROMs and a barcode sensor. It decodes CPU writes in the upper half of the address space into a few control registers. These registers select a 16 KiB program bank and the nametable mirroring. They also drive the clock and data lines of two bit-banged serial EEPROMs. One clock line goes to each EEPROM, and the two share one data line. Writes aimed at the scanline interrupt counter are not handled here. They are passed out as decoded strobes together with their data byte, so that a separate counter can consume them.

For CPU reads in the save-RAM window, the block builds a status byte. One bit carries the resolved level of the shared open-drain data line. Another bit carries the barcode sensor output. All other bits repeat the last value seen on the CPU data bus. The data line is released whenever the direction bit is set. In that state only the EEPROMs can pull it low, and software can sample it.

Top module: `joint_cart_ctrl`

## Requirements
- R1: After synchronous reset, the bank register is 0, mirroring is 0, both clock outputs are 1, the driven data value is 1, the release bit is 1, and the open-bus latch is 0.
- R2: An enabled write (cpu_rnw=0) decodes as a register write when address bit 15 is 1. The register is chosen by address bits 3:0 alone. Low offsets 0, 1, 2 and 3 all load ee_scl_ext from data bit 3, one clock after the write.
- R3: Offset 8 loads the bank register from data bits BANK_W-1:0. For addresses with bit 15 set and bit 14 clear, prg_addr equals {bank, cpu_addr[13:0]}.
- R4: For addresses with bits 15 and 14 set, prg_addr equals {all ones, cpu_addr[13:0]}, which is the last bank, whatever the bank register holds.
- R5: Offset 9 loads mirror_mode from data bits 1:0. The encoding is 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R6: Offset 13 (hex D) loads three fields. Data bit 5 goes to ee_scl_int, bit 6 to ee_sda_drive and bit 7 to ee_sda_release, where 1 means released.
- R7: In the cycle of an enabled write, offset 10 pulses irq_ctrl_stb, offset 11 pulses irq_latch_lo_stb and offset 12 pulses irq_latch_hi_stb. irq_data carries cpu_data_in, and at most one strobe is high.
- R8: Decoding sees only bit 15 and bits 3:0 of the address, so $FFF8 acts as offset 8. Offsets 4-7, 14 and 15, and any write with bit 15 clear, change no output.
- R9: An enabled read in $6000-$7FFF returns the resolved data line on bit 4 and barcode_in on bit 3. The other bits come from the open-bus latch.
- R10: ee_sda_line equals (ee_sda_release OR ee_sda_drive) AND ee_dout_int AND ee_dout_ext.
- R11: On every enabled cycle, the open-bus latch takes cpu_data_in. The exception is a read in the window of R9, where it takes the byte returned. Outside such reads, cpu_rdata shows the latch.
- R12: Enabled reads at addresses with bit 15 set change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_en | input | 1 | CPU access valid this cycle |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 16 | CPU address |
| cpu_data_in | input | 8 | Value on the CPU data bus this cycle |
| cpu_rdata | output | 8 | Status byte / open bus |
| prg_addr | output | BANK_W+14 | Program ROM address |
| mirror_mode | output | 2 | Nametable mirroring select |
| ee_scl_ext | output | 1 | Clock of the cartridge EEPROM |
| ee_scl_int | output | 1 | Clock of the base-unit EEPROM |
| ee_sda_drive | output | 1 | Data value driven onto the shared line |
| ee_sda_release | output | 1 | 1 = data line released for reading |
| ee_sda_line | output | 1 | Resolved level of the shared data line |
| ee_dout_int | input | 1 | Open-drain output of the base-unit EEPROM |
| ee_dout_ext | input | 1 | Open-drain output of the cartridge EEPROM (tie 1 if absent) |
| barcode_in | input | 1 | Serial barcode sensor level |
| irq_ctrl_stb | output | 1 | Interrupt control write strobe |
| irq_latch_lo_stb | output | 1 | Interrupt latch low byte strobe |
| irq_latch_hi_stb | output | 1 | Interrupt latch high byte strobe |
| irq_data | output | 8 | Data byte for the interrupt strobes |

## Verification
The hardest case to reach is one where the open-bus latch, the release bit and both EEPROM outputs all affect a single returned byte. In that case a window read must show the wired-AND result on bit 4 while the surrounding bits repeat a value written many cycles earlier. The stimulus reaches it by interleaving control writes, which toggle release and drive, with unrelated data-bus traffic and window reads. It also sweeps both EEPROM outputs and the barcode level. Aliased addresses such as $FFF8 and $A003, and unused offsets, are placed between these reads so that any stray decode would show up in the next compared byte.

// File: rtl/jcart_pkg.sv
package jcart_pkg;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_ONE_LO = 2'd2,
        MIR_ONE_HI = 2'd3
    } mirror_e;

    localparam logic [3:0] OFF_BANK    = 4'h8;
    localparam logic [3:0] OFF_MIRROR  = 4'h9;
    localparam logic [3:0] OFF_IRQ_CTL = 4'hA;
    localparam logic [3:0] OFF_IRQ_LO  = 4'hB;
    localparam logic [3:0] OFF_IRQ_HI  = 4'hC;
    localparam logic [3:0] OFF_EECTL   = 4'hD;

    localparam int SCL_EXT_BIT = 3;
    localparam int SCL_INT_BIT = 5;
    localparam int SDA_BIT     = 6;
    localparam int REL_BIT     = 7;
    localparam int RD_SDA_BIT  = 4;
    localparam int RD_BC_BIT   = 3;

    typedef struct packed {
        logic scl_ext;
        logic bank;
        logic mirror;
        logic irq_ctl;
        logic irq_lo;
        logic irq_hi;
        logic eectl;
    } wr_stb_t;

    typedef struct packed {
        logic rel;
        logic sda;
        logic scl_int;
    } eectl_t;

    function automatic logic in_save_window(input logic [15:0] a);
        return a[15:13] == 3'b011;
    endfunction

endpackage

// File: rtl/jc_wr_decode.sv
module jc_wr_decode
    import jcart_pkg::*;
#(
    parameter int SCL_MIRRORS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_en,
    input  logic       cpu_rnw,
    input  logic       addr_hi,
    input  logic [3:0] addr_lo,
    output wr_stb_t    stb
);
    logic                   wr_cyc;
    logic [SCL_MIRRORS-1:0] scl_hit;

    assign wr_cyc = cpu_en && !cpu_rnw && addr_hi;

    for (genvar i = 0; i < SCL_MIRRORS; i++) begin : g_scl_alias
        assign scl_hit[i] = (addr_lo == 4'(i));
    end

    always_comb begin
        stb         = '0;
        stb.scl_ext = wr_cyc && (|scl_hit);
        stb.bank    = wr_cyc && (addr_lo == OFF_BANK);
        stb.mirror  = wr_cyc && (addr_lo == OFF_MIRROR);
        stb.irq_ctl = wr_cyc && (addr_lo == OFF_IRQ_CTL);
        stb.irq_lo  = wr_cyc && (addr_lo == OFF_IRQ_LO);
        stb.irq_hi  = wr_cyc && (addr_lo == OFF_IRQ_HI);
        stb.eectl   = wr_cyc && (addr_lo == OFF_EECTL);
    end

    // R7
    stb_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stb));

    // R8
    no_lowhalf_write_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_hi |-> (stb == '0));

endmodule

// File: rtl/jc_ctrl_regs.sv
module jc_ctrl_regs
    import jcart_pkg::*;
#(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_stb_t           stb,
    input  logic [7:0]        wdata,
    output logic [BANK_W-1:0] bank,
    output mirror_e           mirror,
    output logic              scl_ext,
    output eectl_t            eectl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            bank    <= '0;
            mirror  <= MIR_VERT;
            scl_ext <= 1'b1;
            eectl   <= '{rel: 1'b1, sda: 1'b1, scl_int: 1'b1};
        end else begin
            if (stb.bank)    bank    <= wdata[BANK_W-1:0];
            if (stb.mirror)  mirror  <= mirror_e'(wdata[1:0]);
            if (stb.scl_ext) scl_ext <= wdata[SCL_EXT_BIT];
            if (stb.eectl) begin
                eectl.rel     <= wdata[REL_BIT];
                eectl.sda     <= wdata[SDA_BIT];
                eectl.scl_int <= wdata[SCL_INT_BIT];
            end
        end
    end

    // R6
    eectl_load_chk: assert property (@(posedge clk) disable iff (rst)
        stb.eectl |=> (eectl.rel == $past(wdata[REL_BIT])) &&
                      (eectl.scl_int == $past(wdata[SCL_INT_BIT])));

    // R3
    bank_load_chk: assert property (@(posedge clk) disable iff (rst)
        stb.bank |=> bank == $past(wdata[BANK_W-1:0]));

    // R12
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb.bank |=> $stable(bank));

endmodule

// File: rtl/jc_prg_map.sv
module jc_prg_map #(
    parameter int BANK_W = 4,
    localparam int PRG_AW = BANK_W + 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [14:0]       cpu_addr,
    input  logic [BANK_W-1:0] bank,
    output logic [PRG_AW-1:0] prg_addr
);
    localparam logic [BANK_W-1:0] LAST_BANK = '1;

    logic [BANK_W-1:0] sel_bank;

    assign sel_bank = cpu_addr[14] ? LAST_BANK : bank;
    assign prg_addr = {sel_bank, cpu_addr[13:0]};

    // R4
    fixed_upper_chk: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[14] |-> (&prg_addr[PRG_AW-1:14]));

endmodule

// File: rtl/jc_read_port.sv
module jc_read_port
    import jcart_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpu_en,
    input  logic       win_rd,
    input  logic [7:0] bus_in,
    input  logic       sda_line,
    input  logic       barcode,
    output logic [7:0] rdata
);
    logic [7:0] latch_q;

    always_comb begin
        rdata = latch_q;
        if (win_rd) begin
            rdata[RD_SDA_BIT] = sda_line;
            rdata[RD_BC_BIT]  = barcode;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         latch_q <= '0;
        else if (cpu_en) latch_q <= win_rd ? rdata : bus_in;
    end

    // R9
    status_bits_chk: assert property (@(posedge clk) disable iff (rst)
        win_rd |-> (rdata[RD_BC_BIT] == barcode) && (rdata[RD_SDA_BIT] == sda_line));

    // R11
    latch_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_en && !win_rd) |=> (!win_rd -> rdata == $past(bus_in)));

endmodule

// File: rtl/joint_cart_ctrl.sv
module joint_cart_ctrl
    import jcart_pkg::*;
#(
    parameter int BANK_W = 4,
    localparam int PRG_AW = BANK_W + 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_en,
    input  logic              cpu_rnw,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_data_in,
    output logic [7:0]        cpu_rdata,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [1:0]        mirror_mode,
    output logic              ee_scl_ext,
    output logic              ee_scl_int,
    output logic              ee_sda_drive,
    output logic              ee_sda_release,
    output logic              ee_sda_line,
    input  logic              ee_dout_int,
    input  logic              ee_dout_ext,
    input  logic              barcode_in,
    output logic              irq_ctrl_stb,
    output logic              irq_latch_lo_stb,
    output logic              irq_latch_hi_stb,
    output logic [7:0]        irq_data
);
    wr_stb_t           stb;
    logic [BANK_W-1:0] bank;
    mirror_e           mirror;
    eectl_t            eectl;
    logic              win_rd;

    jc_wr_decode #(.SCL_MIRRORS(4)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .cpu_en  (cpu_en),
        .cpu_rnw (cpu_rnw),
        .addr_hi (cpu_addr[15]),
        .addr_lo (cpu_addr[3:0]),
        .stb     (stb)
    );

    jc_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .stb     (stb),
        .wdata   (cpu_data_in),
        .bank    (bank),
        .mirror  (mirror),
        .scl_ext (ee_scl_ext),
        .eectl   (eectl)
    );

    jc_prg_map #(.BANK_W(BANK_W)) u_prg (
        .clk      (clk),
        .rst      (rst),
        .cpu_addr (cpu_addr[14:0]),
        .bank     (bank),
        .prg_addr (prg_addr)
    );

    assign ee_scl_int     = eectl.scl_int;
    assign ee_sda_drive   = eectl.sda;
    assign ee_sda_release = eectl.rel;
    assign ee_sda_line    = (eectl.rel | eectl.sda) & ee_dout_int & ee_dout_ext;
    assign mirror_mode    = mirror;

    assign win_rd = cpu_en && cpu_rnw && in_save_window(cpu_addr);

    jc_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .cpu_en   (cpu_en),
        .win_rd   (win_rd),
        .bus_in   (cpu_data_in),
        .sda_line (ee_sda_line),
        .barcode  (barcode_in),
        .rdata    (cpu_rdata)
    );

    assign irq_ctrl_stb     = stb.irq_ctl;
    assign irq_latch_lo_stb = stb.irq_lo;
    assign irq_latch_hi_stb = stb.irq_hi;
    assign irq_data         = cpu_data_in;

    // R10
    sda_pull_chk: assert property (@(posedge clk) disable iff (rst)
        (!ee_dout_int || !ee_dout_ext) |-> !ee_sda_line);

    // R2
    scl_ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(cpu_en && !cpu_rnw && cpu_addr[15] && cpu_addr[3:2] == 2'b00) |=> $stable(ee_scl_ext));

endmodule

// File: tb/sim_joint_cart_ctrl.sv
module sim_joint_cart_ctrl;
    localparam int CLK_P  = 10;
    localparam int BANK_W = 4;
    localparam int AW     = BANK_W + 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_en = 1'b0, cpu_rnw = 1'b1;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    cpu_data_in = '0;
    logic [7:0]    cpu_rdata;
    logic [AW-1:0] prg_addr;
    logic [1:0]    mirror_mode;
    logic          ee_scl_ext, ee_scl_int, ee_sda_drive, ee_sda_release, ee_sda_line;
    logic          ee_dout_int = 1'b1, ee_dout_ext = 1'b1, barcode_in = 1'b0;
    logic          irq_ctrl_stb, irq_latch_lo_stb, irq_latch_hi_stb;
    logic [7:0]    irq_data;

    always #(CLK_P/2) clk = ~clk;

    joint_cart_ctrl #(.BANK_W(BANK_W)) u0 (.*);

    int vectors = 0;
    int fails   = 0;

    // behavioural reference state
    int m_bank, m_mir, m_scl_ext, m_scl_int, m_sda, m_rel, m_latch;
    int exp_rd;

    task automatic model_reset();
        m_bank = 0; m_mir = 0; m_scl_ext = 1; m_scl_int = 1;
        m_sda = 1; m_rel = 1; m_latch = 0;
    endtask

    task automatic chk(string tag, int act, int exp);
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(bit en, bit rnw, int a, int d, bit si, bit se, bit bc, string ctx);
        int  line, off, prg_exp;
        bit  wr, win;
        @(negedge clk);
        cpu_en = en; cpu_rnw = rnw; cpu_addr = 16'(a); cpu_data_in = 8'(d);
        ee_dout_int = si; ee_dout_ext = se; barcode_in = bc;
        #(CLK_P/4);
        vectors++;
        wr   = en && !rnw && a[15];
        off  = a & 15;
        win  = en && rnw && ((a >> 13) == 3);
        line = ((m_rel | m_sda) & si & se);
        exp_rd = win ? ((m_latch & 8'hE7) | (line << 4) | (int'(bc) << 3)) : m_latch;
        prg_exp = a[14] ? (((1 << BANK_W) - 1) << 14) | (a & 16'h3FFF)
                        : (m_bank << 14) | (a & 16'h3FFF);
        chk({a[14] ? "R4 prg " : "R3 prg ", ctx}, int'(prg_addr), prg_exp);
        chk({"R5 mirror ", ctx}, int'(mirror_mode), m_mir);
        chk({"R2 scl_ext ", ctx}, int'(ee_scl_ext), m_scl_ext);
        chk({"R6 scl_int ", ctx}, int'(ee_scl_int), m_scl_int);
        chk({"R6 sda_drive ", ctx}, int'(ee_sda_drive), m_sda);
        chk({"R6 release ", ctx}, int'(ee_sda_release), m_rel);
        chk({"R10 sda_line ", ctx}, int'(ee_sda_line), line);
        chk({win ? "R9 rdata " : "R11 rdata ", ctx}, int'(cpu_rdata), exp_rd);
        chk({"R7 irq_ctrl ", ctx}, int'(irq_ctrl_stb), int'(wr && off == 10));
        chk({"R7 irq_lo ", ctx}, int'(irq_latch_lo_stb), int'(wr && off == 11));
        chk({"R7 irq_hi ", ctx}, int'(irq_latch_hi_stb), int'(wr && off == 12));
        chk({"R7 irq_data ", ctx}, int'(irq_data), d & 255);
        @(posedge clk);
        if (wr) begin
            if (off < 4) m_scl_ext = (d >> 3) & 1;
            if (off == 8) m_bank = d & ((1 << BANK_W) - 1);
            if (off == 9) m_mir = d & 3;
            if (off == 13) begin
                m_scl_int = (d >> 5) & 1; m_sda = (d >> 6) & 1; m_rel = (d >> 7) & 1;
            end
        end
        if (en) m_latch = win ? exp_rd : (d & 255);
    endtask

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset values seen on idle cycles
        apply(0, 1, 16'h0000, 0, 1, 1, 0, "R1 reset");
        apply(0, 1, 16'hC123, 0, 1, 1, 0, "R1 reset");
        // R2 all four clock aliases
        apply(1, 0, 16'h8000, 8'h00, 1, 1, 0, "R2 off0");
        apply(1, 0, 16'h8001, 8'h08, 1, 1, 0, "R2 off1");
        apply(1, 0, 16'h8002, 8'hF7, 1, 1, 0, "R2 off2");
        apply(1, 0, 16'h8003, 8'h08, 1, 1, 0, "R2 off3");
        // R3 bank select and window
        apply(1, 0, 16'h8008, 8'h05, 1, 1, 0, "R3 bank5");
        apply(1, 1, 16'h9ABC, 8'h11, 1, 1, 0, "R3 low read");
        apply(1, 1, 16'hFFFF, 8'h22, 1, 1, 0, "R4 top read");
        // R8 aliased addresses
        apply(1, 0, 16'hFFF8, 8'h0A, 1, 1, 0, "R8 alias bank");
        apply(1, 0, 16'hA003, 8'h00, 1, 1, 0, "R8 alias scl");
        apply(1, 0, 16'hC009, 8'h02, 1, 1, 0, "R8 alias mirror R5");
        // R5 all encodings
        for (int i = 0; i < 4; i++) apply(1, 0, 16'h8009, i, 1, 1, 0, "R5 mirror");
        // R8 ignored offsets and low-half writes
        apply(1, 0, 16'h8004, 8'hFF, 1, 1, 0, "R8 off4");
        apply(1, 0, 16'h800E, 8'h00, 1, 1, 0, "R8 offE");
        apply(1, 0, 16'h800F, 8'h00, 1, 1, 0, "R8 offF");
        apply(1, 0, 16'h7FF8, 8'h0F, 1, 1, 0, "R8 low bank");
        apply(1, 0, 16'h600D, 8'h00, 1, 1, 0, "R8 low ctrl");
        // R12 reads in register space
        apply(1, 1, 16'h8008, 8'h0C, 1, 1, 0, "R12 read bank");
        apply(1, 1, 16'h800D, 8'h00, 1, 1, 0, "R12 read ctrl");
        // R7 strobes
        apply(1, 0, 16'h800A, 8'h3C, 1, 1, 0, "R7 ctl");
        apply(1, 0, 16'h800B, 8'h5A, 1, 1, 0, "R7 lo");
        apply(1, 0, 16'hE00C, 8'hA5, 1, 1, 0, "R7 hi");
        apply(1, 1, 16'h800A, 8'h3C, 1, 1, 0, "R7 read no stb");
        // R6 / R10 / R9 interplay
        apply(1, 0, 16'h800D, 8'h00, 1, 1, 1, "R6 drive low");
        apply(1, 1, 16'h6000, 8'hFF, 1, 1, 1, "R9 driven low");
        apply(1, 0, 16'h800D, 8'h60, 1, 1, 0, "R6 drive high");
        apply(1, 1, 16'h7FFF, 8'h00, 1, 0, 0, "R9 ext pulls");
        apply(1, 0, 16'h800D, 8'h80, 1, 1, 0, "R6 release");
        for (int k = 0; k < 8; k++)
            apply(1, 1, 16'h6000 + k * 16'h0111, 8'hA5, k[0], k[1], k[2], "R9 sweep");
        apply(0, 1, 16'h6000, 8'h00, 0, 1, 1, "R11 no enable");
        apply(1, 0, 16'h1234, 8'hC3, 1, 1, 0, "R11 bus traffic");
        apply(1, 1, 16'h6ABC, 8'h00, 1, 1, 1, "R11 latch in read");
        // mixed traffic
        for (int n = 0; n < 500; n++) begin
            int a;
            case ($urandom_range(0, 3))
                0: a = 16'h8000 | ($urandom_range(0, 2047) << 4) | $urandom_range(0, 15);
                1: a = 16'h6000 | $urandom_range(0, 8191);
                2: a = 16'h800D;
                default: a = $urandom_range(0, 65535);
            endcase
            apply(1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)), a,
                  $urandom_range(0, 255), 1'($urandom_range(0, 3) != 0),
                  1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)), "R8 mixed");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule